// File: doc/BRIEF.md
# Multiprocessor system control registers

This block is a small memory-mapped register set for a multiprocessor system. A processor can write a halt request that carries an exit code, read back its own processor index, read how many processors are active, and set the level of any one of the per-processor interrupt lines. Each interrupt output is meant to drive the level-sensitive external interrupt input of the matching processor.

Accesses arrive on a simple single-cycle register bus. Each access carries a byte address, a write flag, an access size and right-justified write data, together with the index of the processor making the request. Before decoding, the address is ANDed with 0x2F, so the register set repeats across the wider address space. Read data is registered. It appears in the cycle after the read request and stays there until the next read.

Top module: `mp_sysctl`

## Requirements
- R1: A write (req=1, wr=1) to masked offset 0x00 raises `halt` for exactly the one cycle after the write's clock edge, and `exit_code` takes `wdata[7:0]`. `halt` is low in every other cycle.
- R2: After reset, `exit_code`, `halt`, `irq` and `rdata` are all zero. `exit_code` keeps its value until the next halt write or the next reset.
- R3: A read (req=1, wr=0) of masked offset 0x04 makes `rdata` equal the requester's `cpu_id`, zero-extended, from the cycle after the request.
- R4: A read of masked offset 0x0A returns NCPU when HAS_COUNT is 1, and 0 when HAS_COUNT is 0.
- R5: A write to masked offset 0x08 with `size` not equal to 0 (size encoding: 0 = one byte, 1 = two bytes, 2 = four bytes) selects line `wdata[7:0]` and drives it to 1 when `wdata[15:8]` is nonzero, or to 0 when it is zero. For example, 0x0102 drives line 2 high. The new level is visible from the cycle after the write.
- R6: A one-byte write (size=0) to the interrupt register drives the selected line to 0, whatever `wdata[15:8]` holds.
- R7: Each interrupt line holds its last written level. Only a write that selects that line changes it.
- R8: An interrupt write that selects a line index of NCPU or above changes no `irq` bit.
- R9: The address is decoded as `addr & 0x2F`. For example, 0x44 reads the processor index, 0xC8 is the interrupt register and 0x10 is the halt register.
- R10: A read of any other masked offset returns 0. A write to any offset other than 0x00 and 0x08 changes neither `halt`, `exit_code` nor `irq`.
- R11: `rdata` changes only on a read request. Writes and idle cycles leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Access request, one cycle per access |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 8 | Byte address, masked with 0x2F before decoding |
| size | input | 2 | Access size: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| wdata | input | 32 | Right-justified write data |
| cpu_id | input | ID_W | Index of the requesting processor |
| rdata | output | 32 | Registered read data from the last read |
| halt | output | 1 | One-cycle halt request strobe |
| exit_code | output | 8 | Exit status from the last halt write |
| irq | output | NCPU | Level-held interrupt line for each processor |

## Verification
Every result of this block sits one register stage behind its request. A read's data, a halt strobe with its exit code, and a new interrupt level all appear in the cycle after the edge that accepts the request. The bench drives each access on a falling edge and drops `req` on the next falling edge. It compares all outputs at that second falling edge, which is the first cycle in which the result is due. It then compares them again after an idle cycle. That second comparison confirms that `halt` has fallen and that `rdata`, `exit_code` and `irq` have held.

// File: rtl/mp_sysctl.sv
module mp_sysctl #(
  parameter int NCPU      = 4,
  parameter bit HAS_COUNT = 1'b1,
  parameter int ID_W      = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic            wr,
  input  logic [7:0]      addr,
  input  logic [1:0]      size,
  input  logic [31:0]     wdata,
  input  logic [ID_W-1:0] cpu_id,
  output logic [31:0]     rdata,
  output logic            halt,
  output logic [7:0]      exit_code,
  output logic [NCPU-1:0] irq
);
  localparam logic [7:0] ADDR_MASK = 8'h2F;
  localparam logic [7:0] OFF_HALT  = 8'h00;
  localparam logic [7:0] OFF_ID    = 8'h04;
  localparam logic [7:0] OFF_IRQ   = 8'h08;
  localparam logic [7:0] OFF_CNT   = 8'h0A;
  localparam logic [31:0] CNT_VAL  = HAS_COUNT ? 32'(NCPU) : 32'd0;

  logic [7:0]  off;
  logic        do_halt, do_irq, do_rd, lvl;
  logic [7:0]  line_sel;
  logic [31:0] rd_next;

  assign off      = addr & ADDR_MASK;
  assign do_halt  = req && wr && (off == OFF_HALT);
  assign do_irq   = req && wr && (off == OFF_IRQ);
  assign do_rd    = req && !wr;
  assign line_sel = wdata[7:0];
  assign lvl      = (size != 2'd0) && (wdata[15:8] != 8'd0);

  always_comb begin
    case (off)
      OFF_ID:  rd_next = 32'(cpu_id);
      OFF_CNT: rd_next = CNT_VAL;
      default: rd_next = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata     <= '0;
      halt      <= 1'b0;
      exit_code <= '0;
    end else begin
      halt <= do_halt;
      if (do_halt) exit_code <= wdata[7:0];
      if (do_rd)   rdata     <= rd_next;
    end
  end

  for (genvar g = 0; g < NCPU; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              irq[g] <= 1'b0;
      else if (do_irq && line_sel == 8'(g))    irq[g] <= lvl;
    end
  end
endmodule

// File: rtl/mp_sysctl_chk.sv
module mp_sysctl_chk #(
  parameter int NCPU      = 4,
  parameter bit HAS_COUNT = 1'b1,
  parameter int ID_W      = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req,
  input logic            wr,
  input logic [7:0]      addr,
  input logic [1:0]      size,
  input logic [31:0]     wdata,
  input logic [ID_W-1:0] cpu_id,
  input logic [31:0]     rdata,
  input logic            halt,
  input logic [7:0]      exit_code,
  input logic [NCPU-1:0] irq
);
  logic [7:0] moff;
  assign moff = addr & 8'h2F;

  // R1
  halt_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && wr && moff == 8'h00) |=> (halt && exit_code == $past(wdata[7:0])));
  // R1
  halt_only_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req && wr && moff == 8'h00) |=> !halt);
  // R2
  exit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req && wr && moff == 8'h00) |=> $stable(exit_code));
  // R3
  id_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !wr && moff == 8'h04) |=> rdata == 32'($past(cpu_id)));
  // R4
  count_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !wr && moff == 8'h0A) |=> rdata == (HAS_COUNT ? 32'(NCPU) : 32'd0));
  // R7
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req && wr && moff == 8'h08) |=> $stable(irq));
  // R8
  irq_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && wr && moff == 8'h08 && int'(wdata[7:0]) >= NCPU) |=> $stable(irq));
  // R5
  irq_single_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $countones(irq ^ $past(irq)) <= 1);
  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req && !wr) |=> $stable(rdata));
endmodule

bind mp_sysctl mp_sysctl_chk #(.NCPU(NCPU), .HAS_COUNT(HAS_COUNT), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .size(size),
  .wdata(wdata), .cpu_id(cpu_id), .rdata(rdata), .halt(halt),
  .exit_code(exit_code), .irq(irq)
);

// File: tb/tb_mp_sysctl.sv
module tb_mp_sysctl;
  localparam int NCPU = 4;
  localparam int ID_W = 2;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, wr = 1'b0;
  logic [7:0] addr = '0;
  logic [1:0] size = '0;
  logic [31:0] wdata = '0;
  logic [ID_W-1:0] cpu_id = '0;
  logic [31:0] rdata;
  logic halt;
  logic [7:0] exit_code;
  logic [NCPU-1:0] irq;

  int n_chk = 0, n_fail = 0;
  logic [31:0] e_rdata = '0;
  logic [7:0] e_exit = '0;
  logic [NCPU-1:0] e_irq = '0;
  logic e_halt = 1'b0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mp_sysctl #(.NCPU(NCPU), .HAS_COUNT(1'b1), .ID_W(ID_W)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .size(size),
    .wdata(wdata), .cpu_id(cpu_id), .rdata(rdata), .halt(halt),
    .exit_code(exit_code), .irq(irq));

  function automatic logic [31:0] exp_read(logic [7:0] a, logic [ID_W-1:0] c);
    logic [7:0] m = a & 8'h2F;
    if (m == 8'h04) return 32'(c);
    if (m == 8'h0A) return NCPU;
    return 32'd0;
  endfunction

  task automatic chk(string req_tag, logic [31:0] act, logic [31:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req_tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, 32'(halt), 32'(e_halt), "halt");
    chk(tag, 32'(exit_code), 32'(e_exit), "exit_code");
    chk(tag, 32'(irq), 32'(e_irq), "irq");
    chk(tag, rdata, e_rdata, "rdata");
  endtask

  task automatic access(string tag, logic w, logic [7:0] a, logic [1:0] s,
                        logic [31:0] d, logic [ID_W-1:0] c);
    logic [7:0] m = a & 8'h2F;
    req = 1'b1; wr = w; addr = a; size = s; wdata = d; cpu_id = c;
    @(negedge clk);
    req = 1'b0;
    e_halt = 1'b0;
    if (!w) e_rdata = exp_read(a, c);
    else if (m == 8'h00) begin e_halt = 1'b1; e_exit = d[7:0]; end
    else if (m == 8'h08 && int'(d[7:0]) < NCPU)
      e_irq[d[7:0]] = (s != 2'd0) && (d[15:8] != 8'd0);
    check_all(tag);
    @(negedge clk);
    e_halt = 1'b0;
    check_all(tag);
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check_all("R2");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R2");

    access("R1", 1'b1, 8'h00, 2'd0, 32'h0000_005A, 2'd1);
    access("R2", 1'b0, 8'h0C, 2'd2, 32'h0, 2'd0);
    access("R3", 1'b0, 8'h04, 2'd0, 32'h0, 2'd3);
    access("R4", 1'b0, 8'h0A, 2'd0, 32'h0, 2'd1);
    access("R5", 1'b1, 8'h08, 2'd1, 32'h0000_0102, 2'd0);
    access("R5", 1'b1, 8'h08, 2'd1, 32'h0000_FF00, 2'd0);
    access("R6", 1'b1, 8'h08, 2'd0, 32'h0000_0102, 2'd2);
    access("R7", 1'b1, 8'h08, 2'd2, 32'h0000_0703, 2'd0);
    access("R8", 1'b1, 8'h08, 2'd1, 32'h0000_0104, 2'd0);
    access("R8", 1'b1, 8'h08, 2'd1, 32'h0000_01FF, 2'd0);
    access("R9", 1'b0, 8'h44, 2'd0, 32'h0, 2'd2);
    access("R9", 1'b1, 8'hC8, 2'd1, 32'h0000_0101, 2'd0);
    access("R9", 1'b1, 8'h10, 2'd0, 32'h0000_0033, 2'd0);
    access("R10", 1'b1, 8'h04, 2'd1, 32'h0000_0101, 2'd0);
    access("R10", 1'b1, 8'h0A, 2'd1, 32'h0000_0102, 2'd0);
    access("R10", 1'b0, 8'h20, 2'd2, 32'h0, 2'd0);
    access("R11", 1'b1, 8'h0C, 2'd2, 32'hFFFF_FFFF, 2'd0);

    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      logic [31:0] d;
      case ($urandom_range(0, 5))
        0: a = 8'h00;
        1: a = 8'h04;
        2, 3: a = 8'h08;
        4: a = 8'h0A;
        default: a = 8'($urandom);
      endcase
      a = a | (8'($urandom) & 8'hD0);
      d = $urandom;
      d[7:0] = 8'($urandom_range(0, 5));
      access("R5", 1'($urandom), a, 2'($urandom_range(0, 2)), d, ID_W'($urandom));
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule